// File: doc/BRIEF.md
# Frame-Sync Serial Converter Write Controller

This block sits on the host side of a four-wire serial link to a converter. It takes one 16-bit word at a time over a valid/ready handshake. It then drives an active-low chip select, an active-low frame-sync strobe that opens inside chip select, a divided serial clock and a data line carrying the word most significant bit first. The converter samples data on falling clock edges. The serial clock rests high, and data moves only on rising clock edges.

Every edge on the link is placed a whole number of system-clock cycles after the one before it. Each minimum timing limit is a parameter in picoseconds and is turned into a cycle count by rounding up against the system clock period. The update that makes the converter act on the word can come from either of two events. In clock-edge mode the controller issues one more rising clock edge after the last bit. In frame-sync mode it releases frame sync while the clock is still low. A mode pin selects between them per word. A single-cycle done pulse marks the end of each frame.

Input handshake rules: a word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the link is idle and the frame-sync recovery time has passed. A source that sees `in_ready` low must hold its word and may keep `in_valid` high; nothing is taken until `in_ready` returns. `upd_on_fs` is sampled on the same transfer edge as the word.

Top module: `fsdac_write_ctl`

## Requirements
- R1: Each frame carries exactly 16 data bits, D15 first. Each bit is presented for exactly one falling serial-clock edge while frame sync is low, and the 16 bits taken on those edges equal the accepted word.
- R2: The data line is stable for at least SU_PS before each falling serial-clock edge. It does not change until at least HD_PS after that edge.
- R3: Frame sync is low only while chip select is low, and it falls at least CSFS_PS after chip select falls.
- R4: The first falling serial-clock edge of a frame comes at least FSCK_PS after frame sync falls.
- R5: Within a frame, every serial-clock high phase between two falling edges lasts at least HI_PS, and every low phase ended by a rising edge lasts at least LO_PS.
- R6: Frame sync rises at least C16FS_PS after the 16th falling serial-clock edge.
- R7: With `upd_on_fs`=0 (clock-edge mode), 16 rising serial-clock edges occur while frame sync is low, and the last of them is the update. With `upd_on_fs`=1 (frame-sync mode), 15 occur, the clock stays low until frame sync has risen, and the frame-sync rise is the update.
- R8: Chip select rises at least ENDCS_PS after the update event chosen by the mode.
- R9: Frame sync stays high for at least FSHI_PS between frames, and `in_ready` is low in the cycle in which done is high.
- R10: While a frame is in progress `in_ready` is low and `in_valid` has no effect. No second frame starts and the word being sent is not altered.
- R11: `done` is high for exactly one system-clock cycle per frame, in the first cycle in which chip select is high again.
- R12: During and right after reset, including a reset in mid-frame, chip select, frame sync and serial clock are high, `done` is low, and `in_ready` is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered by the source |
| in_ready | output | 1 | Controller can take a word |
| in_data | input | 16 | Word to send, bit 15 sent first |
| upd_on_fs | input | 1 | Update method for this word: 0 clock edge, 1 frame-sync rise |
| done | output | 1 | One-cycle pulse when the frame closes |
| cs_n | output | 1 | Chip select, active low |
| fs_n | output | 1 | Frame sync, active low |
| sclk | output | 1 | Serial clock, rests high |
| sdo | output | 1 | Serial data, changes on rising sclk |

## Verification
The embedded properties check, on every cycle, the relations between pins that need no timing count. Frame sync lies inside chip select, and chip select is already low when frame sync falls. Falling clock edges occur only inside frame sync, and data never moves on a falling edge. The idle pin levels and the single-cycle done pulse are also checked, along with the rule that frame sync rises with the clock low in frame-sync mode. The minimum widths in nanoseconds, the count of rising edges per mode, the word captured by a receiver model, the ignoring of a held `in_valid` during a frame and the recovery after a mid-frame reset can only be shown by the bench's scenarios. These use fixed and random words in both modes, with every recorded edge interval measured against its limit.

// File: rtl/fsdac_pkg.sv
package fsdac_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_CS_SU   = 3'd1,
    S_FS_SU   = 3'd2,
    S_CK_LO   = 3'd3,
    S_CK_HI   = 3'd4,
    S_CS_HOLD = 3'd5,
    S_GAP     = 3'd6
  } link_state_t;

  // Minimum time in ps to whole system clocks, rounded up, never below one.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                            input int unsigned per_ps);
    int unsigned r;
    r = (t_ps + per_ps - 1) / per_ps;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fsdac_timer.sv
module fsdac_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;

  // A phase loaded with len lasts len cycles, counting the loading cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= len - TW'(1);
    else if (cnt != '0)    cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));
endmodule

// File: rtl/fsdac_shifter.sv
module fsdac_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              advance,
  output logic              bit_out
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (load)    sr <= word;
    else if (advance) sr <= {sr[WORD_W-2:0], 1'b0};
  end

  assign bit_out = sr[WORD_W-1];

  // A shift never coincides with a new word: the bit in flight is untouched.
  p_no_load_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && advance));
endmodule

// File: rtl/fsdac_seq.sv
module fsdac_seq
  import fsdac_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned TW     = 4,
  parameter int unsigned N_CSFS = 2,
  parameter int unsigned L_FSU  = 1,
  parameter int unsigned L_LO   = 4,
  parameter int unsigned L_HI   = 4,
  parameter int unsigned L_LAST = 4,
  parameter int unsigned N_END  = 2,
  parameter int unsigned N_GAP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_fs_in,
  output logic          idle,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_len,
  output logic          bit_adv,
  output logic          cs_n,
  output logic          fs_n,
  output logic          sclk,
  output logic          done
);
  localparam int unsigned NW = $clog2(WORD_W + 1);
  localparam logic [NW-1:0] FALLS_ALL  = NW'(WORD_W);
  localparam logic [NW-1:0] FALLS_PREV = NW'(WORD_W - 1);

  link_state_t st, st_d;
  logic [NW-1:0] nfall, nfall_d;
  logic mode_q, mode_d;
  logic cs_q, cs_d, fs_q, fs_d, ck_q, ck_d, done_q, done_d;

  always_comb begin
    st_d     = st;
    nfall_d  = nfall;
    mode_d   = mode_q;
    cs_d     = cs_q;
    fs_d     = fs_q;
    ck_d     = ck_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    bit_adv  = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        cs_d     = 1'b0;
        mode_d   = mode_fs_in;
        nfall_d  = '0;
        tmr_load = 1'b1;
        tmr_len  = TW'(N_CSFS);
        st_d     = S_CS_SU;
      end
      S_CS_SU: if (tmr_expired) begin
        fs_d     = 1'b0;
        tmr_load = 1'b1;
        tmr_len  = TW'(L_FSU);
        st_d     = S_FS_SU;
      end
      S_FS_SU: if (tmr_expired) begin
        ck_d     = 1'b0;
        nfall_d  = nfall + NW'(1);
        tmr_load = 1'b1;
        tmr_len  = (WORD_W == 1) ? TW'(L_LAST) : TW'(L_LO);
        st_d     = S_CK_LO;
      end
      S_CK_LO: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (nfall != FALLS_ALL) begin
          ck_d    = 1'b1;
          bit_adv = 1'b1;
          tmr_len = TW'(L_HI);
          st_d    = S_CK_HI;
        end else begin
          if (mode_q) fs_d = 1'b1;   // update by frame-sync rise
          else        ck_d = 1'b1;   // update by the extra rising edge
          tmr_len = TW'(N_END);
          st_d    = S_CS_HOLD;
        end
      end
      S_CK_HI: if (tmr_expired) begin
        ck_d     = 1'b0;
        nfall_d  = nfall + NW'(1);
        tmr_load = 1'b1;
        tmr_len  = (nfall == FALLS_PREV) ? TW'(L_LAST) : TW'(L_LO);
        st_d     = S_CK_LO;
      end
      S_CS_HOLD: if (tmr_expired) begin
        cs_d     = 1'b1;
        fs_d     = 1'b1;
        ck_d     = 1'b1;
        done_d   = 1'b1;
        tmr_load = 1'b1;
        tmr_len  = TW'(N_GAP);
        st_d     = S_GAP;
      end
      S_GAP: if (tmr_expired) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      nfall  <= '0;
      mode_q <= 1'b0;
      cs_q   <= 1'b1;
      fs_q   <= 1'b1;
      ck_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st     <= st_d;
      nfall  <= nfall_d;
      mode_q <= mode_d;
      cs_q   <= cs_d;
      fs_q   <= fs_d;
      ck_q   <= ck_d;
      done_q <= done_d;
    end
  end

  assign idle = (st == S_IDLE);
  assign cs_n = cs_q;
  assign fs_n = fs_q;
  assign sclk = ck_q;
  assign done = done_q;

  p_fs_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_q |-> !cs_q);
  p_cs_leads_fs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_q) |-> $past(!cs_q));
  p_fall_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ck_q) |-> !fs_q);
  p_fall_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nfall <= FALLS_ALL);
  p_fs_update_low_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_q) && mode_q) |-> !ck_q);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_on_cs_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> done_q);
  p_idle_pins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (cs_q && fs_q && ck_q));
  p_gap_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st != S_IDLE));
endmodule

// File: rtl/fsdac_write_ctl.sv
module fsdac_write_ctl
  import fsdac_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned CSFS_PS  = 10000,
  parameter int unsigned FSCK_PS  = 8000,
  parameter int unsigned SU_PS    = 8000,
  parameter int unsigned HD_PS    = 5000,
  parameter int unsigned HI_PS    = 25000,
  parameter int unsigned LO_PS    = 25000,
  parameter int unsigned C16FS_PS = 10000,
  parameter int unsigned ENDCS_PS = 10000,
  parameter int unsigned FSHI_PS  = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              upd_on_fs,
  output logic              done,
  output logic              cs_n,
  output logic              fs_n,
  output logic              sclk,
  output logic              sdo
);
  localparam int unsigned N_CSFS = ps_to_cyc(CSFS_PS, CLK_PS);
  localparam int unsigned N_FSCK = ps_to_cyc(FSCK_PS, CLK_PS);
  localparam int unsigned N_SU   = ps_to_cyc(SU_PS, CLK_PS);
  localparam int unsigned N_HD   = ps_to_cyc(HD_PS, CLK_PS);
  localparam int unsigned N_HI   = ps_to_cyc(HI_PS, CLK_PS);
  localparam int unsigned N_LO   = ps_to_cyc(LO_PS, CLK_PS);
  localparam int unsigned N_C16  = ps_to_cyc(C16FS_PS, CLK_PS);
  localparam int unsigned N_END  = ps_to_cyc(ENDCS_PS, CLK_PS);
  localparam int unsigned N_GAP  = ps_to_cyc(FSHI_PS, CLK_PS);
  localparam int unsigned L_FSU  = umax(N_FSCK, N_SU);
  localparam int unsigned L_LO   = umax(N_LO, N_HD);
  localparam int unsigned L_HI   = umax(N_HI, N_SU);
  localparam int unsigned L_LAST = umax(L_LO, N_C16);
  localparam int unsigned MAXN   = umax(umax(umax(N_CSFS, L_FSU), umax(L_LO, L_HI)),
                                        umax(umax(L_LAST, N_END), N_GAP));
  localparam int unsigned TW     = $clog2(MAXN + 1);

  logic          idle, start, tmr_load, tmr_expired, bit_adv;
  logic [TW-1:0] tmr_len;

  assign in_ready = idle;
  assign start    = in_valid && idle;

  fsdac_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_expired)
  );

  fsdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .word(in_data),
    .advance(bit_adv), .bit_out(sdo)
  );

  fsdac_seq #(
    .WORD_W(WORD_W), .TW(TW), .N_CSFS(N_CSFS), .L_FSU(L_FSU), .L_LO(L_LO),
    .L_HI(L_HI), .L_LAST(L_LAST), .N_END(N_END), .N_GAP(N_GAP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_fs_in(upd_on_fs), .idle(idle),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_len(tmr_len),
    .bit_adv(bit_adv), .cs_n(cs_n), .fs_n(fs_n), .sclk(sclk), .done(done)
  );

  p_data_still_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo));
  p_ready_link_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cs_n && fs_n));
endmodule

// File: tb/fsdac_write_ctl_test.sv
module fsdac_write_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, upd_on_fs = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, done, cs_n, fs_n, sclk, sdo;

  int checks = 0, fails = 0, cyc = 0;

  fsdac_write_ctl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .upd_on_fs(upd_on_fs), .done(done),
    .cs_n(cs_n), .fs_n(fs_n), .sclk(sclk), .sdo(sdo)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Receiver model and edge-interval monitor, sampled mid-cycle.
  logic pcs = 1, pfs = 1, pck = 1, psd = 0;
  int t_csf = 0, t_fsf = 0, t_fsr = -1, t_fall = 0, t_rise = 0, t_sd = 0, t_upd = 0;
  int ncap = 0, rises = 0, frames = 0, dones = 0;
  int last_ncap = 0, last_rises = 0;
  logic [15:0] cap = '0, last_word = '0;
  logic mon_fs_mode = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pcs = 1; pfs = 1; pck = 1; psd = sdo; ncap = 0; rises = 0; t_fsr = -1;
    end else begin
      if (pcs && !cs_n) t_csf = cyc;
      if (psd != sdo) begin
        if (!fs_n && ncap > 0) chk((cyc - t_fall) * 8 >= 5, "R2 hold", (cyc - t_fall) * 8, 5);
        t_sd = cyc;
      end
      if (pfs && !fs_n) begin
        chk(!cs_n && (cyc - t_csf) * 8 >= 10, "R3 cs to fs", (cyc - t_csf) * 8, 10);
        if (t_fsr >= 0) chk((cyc - t_fsr) * 8 >= 25, "R9 fs high", (cyc - t_fsr) * 8, 25);
        ncap = 0; rises = 0; cap = '0; t_fsf = cyc; mon_fs_mode = upd_on_fs;
      end
      if (pck && !sclk) begin
        chk(!fs_n, "R1 fall inside fs", fs_n, 0);
        if (ncap == 0) chk((cyc - t_fsf) * 8 >= 8, "R4 fs to first fall", (cyc - t_fsf) * 8, 8);
        else           chk((cyc - t_rise) * 8 >= 25, "R5 high", (cyc - t_rise) * 8, 25);
        chk((cyc - t_sd) * 8 >= 8, "R2 setup", (cyc - t_sd) * 8, 8);
        cap = {cap[14:0], sdo};
        ncap++;
        t_fall = cyc;
      end
      if (!pck && sclk && !cs_n && ncap > 0) begin
        chk((cyc - t_fall) * 8 >= 25, "R5 low", (cyc - t_fall) * 8, 25);
        t_rise = cyc;
        if (!fs_n) begin
          rises++;
          if (ncap == 16) t_upd = cyc;
        end
      end
      if (!pfs && fs_n) begin
        if (ncap == 16) chk((cyc - t_fall) * 8 >= 10, "R6 last fall to fs", (cyc - t_fall) * 8, 10);
        if (mon_fs_mode) t_upd = cyc;
        t_fsr = cyc; last_word = cap; last_ncap = ncap; last_rises = rises;
      end
      if (!pcs && cs_n) begin
        chk((cyc - t_upd) * 8 >= 10, "R8 update to cs", (cyc - t_upd) * 8, 10);
        frames++;
      end
      if (done) begin
        dones++;
        chk(cs_n && !pcs, "R11 done with cs rise", {pcs, cs_n}, 2'b01);
      end
      pcs = cs_n; pfs = fs_n; pck = sclk; psd = sdo;
    end
  end

  // {mode, word}: mode 1 = frame-sync update.
  localparam logic [16:0] VEC [0:7] = '{
    17'h0_A5C3, 17'h1_A5C3, 17'h0_FFFF, 17'h1_0000,
    17'h0_8000, 17'h1_0001, 17'h0_0001, 17'h1_7FFE
  };

  task automatic send(input logic [15:0] w, input logic m);
    int n, d0, f0;
    d0 = dones; f0 = frames; n = 0;
    @(negedge clk);
    while (!in_ready && n < 2000) begin @(negedge clk); n++; end
    in_valid = 1'b1; in_data = w; upd_on_fs = m;
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(!in_ready, "R9 ready low at done", in_ready, 0);
    @(negedge clk);
    chk(last_word == w, "R1 word", last_word, w);
    chk(last_ncap == 16, "R1 bit count", last_ncap, 16);
    chk(last_rises == (m ? 15 : 16), "R7 rising edges", last_rises, m ? 15 : 16);
    chk(dones - d0 == 1, "R11 one done", dones - d0, 1);
    chk(frames - f0 == 1, "R10 one frame", frames - f0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && fs_n && sclk, "R12 idle pins", {cs_n, fs_n, sclk}, 3'b111);
    chk(!done, "R12 done low", done, 0);
    chk(in_ready, "R12 ready", in_ready, 1);

    for (int i = 0; i < 8; i++) send(VEC[i][15:0], VEC[i][16]);
    for (int i = 0; i < 16; i++) send(16'($urandom), 1'($urandom));

    // R10: a held in_valid with another word during a frame changes nothing.
    begin
      int f0;
      f0 = frames;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = 16'h3C5A; upd_on_fs = 1'b0;
      @(negedge clk);
      in_data = 16'hC3A5;
      for (int k = 0; k < 40; k++) begin
        chk(!in_ready, "R10 ready low while busy", in_ready, 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(last_word == 16'h3C5A, "R10 word kept", last_word, 16'h3C5A);
      repeat (300) @(negedge clk);
      chk(frames - f0 == 1, "R10 no extra frame", frames - f0, 1);
    end

    // R12: reset in mid-frame returns the link to idle.
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'h1234; upd_on_fs = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n && fs_n && sclk, "R12 mid-frame reset pins", {cs_n, fs_n, sclk}, 3'b111);
    chk(!done, "R12 mid-frame reset done", done, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R12 ready after reset", in_ready, 1);
    send(16'hBEEF, 1'b0);
    send(16'h0F0F, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule